// File: doc/BRIEF.md
# Word-to-bit serializer with selectable bit order, squelch and loopback paths

This block sits at the transmit end of a serial link. It runs on the high-speed bit clock, divides that clock by the word width to produce a word clock, and once per word period pulses a read strobe. On the edge that ends the strobe cycle it takes one parallel word and then sends it out one bit per clock. The bit order is chosen per word, either low bit first or high bit first. The choice is captured when the word is loaded.

An active-low squelch holds the transmit data at zero. Two active-low loopback controls set where data goes. Diagnostic loopback feeds the raw serializer bit to the receive deserializer input. Line loopback replaces the transmit data and clock with the recovered receive data and clock, and while it is on the squelch has no effect. Requesting both loopbacks is not a supported setup: line loopback wins and a configuration error flag is raised. A clock-disable input holds the transmit clock output at zero.

Top module: `ser_tx_core`

## Requirements
- R1: `word_rd_o` is high for exactly one clock in every W clocks (W = 4 by default). The first pulse comes after reset is released. `word_i` and `msb_first_i` are captured on the rising edge that ends a cycle in which `word_rd_o` is high.
- R2: With `msb_first_i` = 0 at capture, the serial order is bit 0, bit 1, bit 2, bit 3. Bit 0 appears in the cycle right after the capture edge, and each later bit appears one clock after the previous one.
- R3: With `msb_first_i` = 1 at capture, the serial order is bit 3, bit 2, bit 1, bit 0, with the same timing as R2.
- R4: A change of `msb_first_i` after capture does not alter the order of the word already loaded.
- R5: While `line_lb_n_i` = 1 and `squelch_n_i` = 0, `tx_data_o` is 0.
- R6: While `line_lb_n_i` = 0, `squelch_n_i` has no effect on `tx_data_o`.
- R7: With `line_lb_n_i` = 0, `tx_data_o` equals `rx_data_i` and `tx_clk_o` equals `rx_clk_i`. With both loopbacks off and `clk_off_i` = 0, `tx_clk_o` follows the bit clock.
- R8: With `diag_lb_n_i` = 0 and `line_lb_n_i` = 1, `deser_in_o` carries the serializer bit, whatever the squelch setting. In every other mode `deser_in_o` equals `rx_data_i`.
- R9: With both loopback controls at 0, line loopback applies and `cfg_err_o` = 1. Otherwise `cfg_err_o` = 0.
- R10: With `clk_off_i` = 1, `tx_clk_o` is 0 in every mode, line loopback included.
- R11: `word_clk_o` is high during the last W/2 cycles of each word period. It is high in the `word_rd_o` cycle and low in the first cycle after capture.
- R12: While `rst_n` is low, `word_rd_o` is 0 and the serializer bit is 0, so `tx_data_o` is 0 when squelch and line loopback are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_i | input | W | Parallel word from the FIFO read side |
| msb_first_i | input | 1 | 1: high bit first, 0: low bit first |
| squelch_n_i | input | 1 | Active-low transmit squelch |
| diag_lb_n_i | input | 1 | Active-low diagnostic loopback enable |
| line_lb_n_i | input | 1 | Active-low line loopback enable |
| clk_off_i | input | 1 | High turns the transmit clock output off |
| rx_data_i | input | 1 | Recovered receive data |
| rx_clk_i | input | 1 | Recovered receive clock |
| word_rd_o | output | 1 | Word read strobe, one cycle per word period |
| word_clk_o | output | 1 | Bit clock divided by W |
| tx_data_o | output | 1 | Transmit serial data |
| tx_clk_o | output | 1 | Transmit clock |
| deser_in_o | output | 1 | Bit sent to the receive deserializer |
| cfg_err_o | output | 1 | Both loopbacks requested |

## Verification
The bench builds the block with the default word width of four. That keeps a word period at four clocks, so every position of both bit orders and the load strobe spacing come up in each of many random words. With W = 4 the order flip made right after capture falls inside a word that is still shifting, and a short run covers all squelch, loopback and clock-disable combinations against the serial stream.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    PATH_NORMAL = 2'd0,
    PATH_DIAG   = 2'd1,
    PATH_LINE   = 2'd2
  } lb_path_e;

  function automatic lb_path_e pick_path(input logic diag_n, input logic line_n);
    if (!line_n)      return PATH_LINE;
    else if (!diag_n) return PATH_DIAG;
    else              return PATH_NORMAL;
  endfunction
endpackage

// File: rtl/ser_word_timer.sv
module ser_word_timer #(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic load_o,
  output logic word_clk_o
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] HALF = CW'(W / 2);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign load_o     = (cnt_q == LAST);
  assign word_clk_o = (cnt_q >= HALF);
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         msb_first_i,
  output logic         bit_o
);
  logic [W-1:0] sreg_q, sreg_d;
  logic         ord_q, ord_d;

  always_comb begin
    sreg_d = sreg_q;
    ord_d  = ord_q;
    if (load_i) begin
      sreg_d = word_i;
      ord_d  = msb_first_i;
    end else if (ord_q) begin
      sreg_d = {sreg_q[W-2:0], 1'b0};
    end else begin
      sreg_d = {1'b0, sreg_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      ord_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      ord_q  <= ord_d;
    end
  end

  assign bit_o = ord_q ? sreg_q[W-1] : sreg_q[0];
endmodule

// File: rtl/ser_out_mux.sv
module ser_out_mux
  import ser_tx_pkg::*;
(
  input  logic ser_bit_i,
  input  logic hs_clk_i,
  input  logic squelch_n_i,
  input  logic diag_lb_n_i,
  input  logic line_lb_n_i,
  input  logic clk_off_i,
  input  logic rx_data_i,
  input  logic rx_clk_i,
  output logic tx_data_o,
  output logic tx_clk_o,
  output logic deser_in_o,
  output logic cfg_err_o
);
  lb_path_e path;

  always_comb begin
    path       = pick_path(diag_lb_n_i, line_lb_n_i);
    tx_data_o  = squelch_n_i ? ser_bit_i : 1'b0;
    tx_clk_o   = hs_clk_i;
    deser_in_o = rx_data_i;
    unique case (path)
      PATH_LINE: begin
        tx_data_o = rx_data_i;
        tx_clk_o  = rx_clk_i;
      end
      PATH_DIAG:   deser_in_o = ser_bit_i;
      default:     ;
    endcase
    if (clk_off_i) tx_clk_o = 1'b0;
    cfg_err_o = !diag_lb_n_i && !line_lb_n_i;
  end
endmodule

// File: rtl/ser_tx_core.sv
module ser_tx_core #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_i,
  input  logic         msb_first_i,
  input  logic         squelch_n_i,
  input  logic         diag_lb_n_i,
  input  logic         line_lb_n_i,
  input  logic         clk_off_i,
  input  logic         rx_data_i,
  input  logic         rx_clk_i,
  output logic         word_rd_o,
  output logic         word_clk_o,
  output logic         tx_data_o,
  output logic         tx_clk_o,
  output logic         deser_in_o,
  output logic         cfg_err_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       ser_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  ser_word_timer #(.W(W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_o     (word_rd_o),
    .word_clk_o (word_clk_o)
  );

  ser_shift #(.W(W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_i      (word_rd_o),
    .word_i      (word_i),
    .msb_first_i (msb_first_i),
    .bit_o       (ser_bit)
  );

  ser_out_mux u_mux (
    .ser_bit_i   (ser_bit),
    .hs_clk_i    (clk),
    .squelch_n_i (squelch_n_i),
    .diag_lb_n_i (diag_lb_n_i),
    .line_lb_n_i (line_lb_n_i),
    .clk_off_i   (clk_off_i),
    .rx_data_i   (rx_data_i),
    .rx_clk_i    (rx_clk_i),
    .tx_data_o   (tx_data_o),
    .tx_clk_o    (tx_clk_o),
    .deser_in_o  (deser_in_o),
    .cfg_err_o   (cfg_err_o)
  );
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
  parameter int W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic word_rd_o,
  input logic squelch_n_i,
  input logic diag_lb_n_i,
  input logic line_lb_n_i,
  input logic clk_off_i,
  input logic rx_data_i,
  input logic tx_data_o,
  input logic tx_clk_o,
  input logic deser_in_o,
  input logic cfg_err_o
);
  localparam int GW = $clog2(W) + 1;
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};
  localparam logic [GW-1:0] GEXP = GW'(W - 1);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (word_rd_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GMAX) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  a_r1_rd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd_o && seen_q) |-> (gap_q == GEXP));
  a_r1_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_rd_o |=> !word_rd_o);
  a_r5_squelch: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lb_n_i && !squelch_n_i) |-> !tx_data_o);
  a_r7_line_data: assert property (@(posedge clk) disable iff (!rst_n)
    !line_lb_n_i |-> (tx_data_o == rx_data_i));
  a_r8_rx_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_lb_n_i || !line_lb_n_i) |-> (deser_in_o == rx_data_i));
  a_r9_cfg_err: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (!diag_lb_n_i && !line_lb_n_i));
  a_r10_clk_off: assert property (@(posedge clk) disable iff (!rst_n)
    clk_off_i |-> !tx_clk_o);
endmodule

bind ser_tx_core ser_tx_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_rd_o   (word_rd_o),
  .squelch_n_i (squelch_n_i),
  .diag_lb_n_i (diag_lb_n_i),
  .line_lb_n_i (line_lb_n_i),
  .clk_off_i   (clk_off_i),
  .rx_data_i   (rx_data_i),
  .tx_data_o   (tx_data_o),
  .tx_clk_o    (tx_clk_o),
  .deser_in_o  (deser_in_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/sim_ser_tx_core.sv
`timescale 1ns/1ps
module sim_ser_tx_core;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] word_i;
  logic         msb_first_i, squelch_n_i, diag_lb_n_i, line_lb_n_i;
  logic         clk_off_i, rx_data_i, rx_clk_i;
  logic         word_rd_o, word_clk_o, tx_data_o, tx_clk_o, deser_in_o, cfg_err_o;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  ser_tx_core #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .msb_first_i(msb_first_i),
    .squelch_n_i(squelch_n_i), .diag_lb_n_i(diag_lb_n_i), .line_lb_n_i(line_lb_n_i),
    .clk_off_i(clk_off_i), .rx_data_i(rx_data_i), .rx_clk_i(rx_clk_i),
    .word_rd_o(word_rd_o), .word_clk_o(word_clk_o), .tx_data_o(tx_data_o),
    .tx_clk_o(tx_clk_o), .deser_in_o(deser_in_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [W-1:0] w, input logic msb, input int k);
    return msb ? w[W-1-k] : w[k];
  endfunction

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  // send one word through the normal or diagnostic path, checking every bit
  task automatic send_word(input logic [W-1:0] w, input logic msb, input logic flip);
    while (!word_rd_o) step();
    chk("R11 word clock high in strobe cycle", word_clk_o, 1'b1);
    word_i      = w;
    msb_first_i = msb;
    for (int k = 0; k < W; k++) begin
      step();
      rx_data_i = 1'($urandom_range(1, 0));
      #1;
      if (k == 0) begin
        chk("R11 word clock low after capture", word_clk_o, 1'b0);
        if (flip) msb_first_i = ~msb;  // R4: late order change
      end
      chk(msb ? (flip ? "R4 order held" : "R3 msb first")
              : (flip ? "R4 order held" : "R2 lsb first"),
          tx_data_o, squelch_n_i ? exp_bit(w, msb, k) : 1'b0);
      if (!squelch_n_i) chk("R5 squelch", tx_data_o, 1'b0);
      chk("R8 deserializer input", deser_in_o,
          (!diag_lb_n_i) ? exp_bit(w, msb, k) : rx_data_i);
      chk("R1 strobe spacing", word_rd_o, (k == W - 1));
      chk("R7 bit clock out", tx_clk_o, !clk_off_i);
    end
  endtask

  task automatic line_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      rx_data_i   = 1'($urandom_range(1, 0));
      rx_clk_i    = 1'($urandom_range(1, 0));
      squelch_n_i = 1'($urandom_range(1, 0));
      #1;
      chk("R6 R7 line data", tx_data_o, rx_data_i);
      chk("R7 line clock", tx_clk_o, clk_off_i ? 1'b0 : rx_clk_i);
      if (clk_off_i) chk("R10 clock off in line loop", tx_clk_o, 1'b0);
      chk("R9 error flag", cfg_err_o, !diag_lb_n_i);
      chk("R9 deserializer from rx", deser_in_o, rx_data_i);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; word_i = '0; msb_first_i = 1'b0; squelch_n_i = 1'b1;
    diag_lb_n_i = 1'b1; line_lb_n_i = 1'b1; clk_off_i = 1'b0;
    rx_data_i = 1'b0; rx_clk_i = 1'b0;
    repeat (3) step();
    chk("R12 reset strobe", word_rd_o, 1'b0);
    chk("R12 reset data", tx_data_o, 1'b0);
    chk("R9 reset error flag", cfg_err_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step();

    // directed corner cases
    send_word(4'b0001, 1'b0, 1'b0);
    send_word(4'b0001, 1'b1, 1'b0);
    send_word(4'b1000, 1'b1, 1'b0);
    send_word(4'b1101, 1'b0, 1'b1);
    send_word(4'b1101, 1'b1, 1'b1);
    squelch_n_i = 1'b0;
    send_word(4'b1111, 1'b0, 1'b0);
    diag_lb_n_i = 1'b0;
    send_word(4'b1010, 1'b1, 1'b0);
    squelch_n_i = 1'b1;
    clk_off_i   = 1'b1;
    send_word(4'b0110, 1'b0, 1'b0);
    chk("R10 clock off", tx_clk_o, 1'b0);
    clk_off_i   = 1'b0;
    diag_lb_n_i = 1'b1;

    // line loopback, squelch toggling
    line_lb_n_i = 1'b0;
    line_cycles(12);
    clk_off_i = 1'b1;
    line_cycles(6);
    clk_off_i = 1'b0;
    diag_lb_n_i = 1'b0;   // both requested
    line_cycles(10);
    line_lb_n_i = 1'b1;
    diag_lb_n_i = 1'b1;
    squelch_n_i = 1'b1;

    // constrained random words
    for (int n = 0; n < 40; n++) begin
      squelch_n_i = ($urandom_range(3, 0) != 0);
      diag_lb_n_i = 1'($urandom_range(1, 0));
      clk_off_i   = ($urandom_range(7, 0) == 0);
      send_word(W'($urandom_range(15, 0)), 1'($urandom_range(1, 0)),
                ($urandom_range(3, 0) == 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule